// File: doc/BRIEF.md
# Dual-Port PHY Control Register Reset Manager

This block keeps the basic control word of each port of a two-port Ethernet PHY. It decides what that word holds after each kind of reset and power-down. A shared hardware reset input captures three strap inputs: speed, autonegotiation enable and duplex. They are captured on the last clock cycle of the reset, and the block keeps a private copy of them. A software reset and the release of a per-port power-down pin both rebuild the word from that copy. Neither one looks at the strap inputs again.

A parallel read/write management port stands in for the serial management interface. After hardware reset it stays closed for a programmable wait, and `mgmt_ready` shows when it is open. Each port drives an output-enable (tristate control) and a port-enable line towards the line side. Register power-down (bit 11) stops the port but keeps management access to it. A power-down pin cuts off both the port and its register access.

Top module: `phy_ctl_reset_mgr`

## Requirements
- R1: On the last clock cycle with `hw_rst` high, each port's control word loads speed strap into bit 13, autonegotiation strap into bit 12 and duplex strap into bit 8, with all other bits 0; the three strap values are also kept as the restore copy.
- R2: A software reset restores bits 13, 12 and 8 from the restore copy and clears every other stored bit; strap input changes since the last hardware reset have no effect.
- R3: Writing a word with bit 15 set starts a software reset; bit 15 reads 1 for exactly SRST_CYC cycles (then 0), reads stay valid meanwhile, writes to that port are ignored meanwhile, and a write with bit 15 clear starts no reset.
- R4: After `hw_rst` falls, `mgmt_ready` stays low for WAIT_CYC = CLK_HZ*READY_NS/1e9 cycles; during that time reads return 16'hFFFF and writes are ignored; once high it stays high until the next hardware reset.
- R5: While `hw_rst` is high, every `port_oe` and `port_en` bit is 0.
- R6: Control bit 11 set drives that port's `port_en` low while `port_oe` stays high, and the port's word stays readable and writable.
- R7: A high `pwrdn_pin` bit drives that port's `port_oe` and `port_en` low; reads of that port return 16'hFFFF and writes to it are ignored.
- R8: When a `pwrdn_pin` bit falls, that port's word equals the restore value (R1 layout, from the restore copy), with bit 15 reading 0.
- R9: Both ports have independent words, software-reset timers and power-down state; an action addressed to one port leaves the other unchanged.
- R10: Priority is hardware reset, then power-down pin, then software reset and writes: a pin asserted during a software reset cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, active high, synchronous |
| strap_speed | input | 1 | Speed strap, sampled at hardware reset |
| strap_aneg | input | 1 | Autonegotiation strap, sampled at hardware reset |
| strap_duplex | input | 1 | Duplex strap, sampled at hardware reset |
| pwrdn_pin | input | NPORTS | Per-port power-down pins, active high |
| mgmt_wr | input | 1 | Write strobe for the addressed port |
| mgmt_port | input | PW | Port select for read and write |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Control word of the selected port, or 16'hFFFF when blocked |
| mgmt_ready | output | 1 | Management access open |
| port_oe | output | NPORTS | Per-port output enable (0 = tristated) |
| port_en | output | NPORTS | Per-port enable |

## Verification
Suppose the restore copy gets corrupted, or a strap is sampled again later. This shows on the very next read after a software reset ends, or on the first read after a pin release. The rebuilt word then differs from the straps that applied at the last hardware reset. A timer that is off by one changes the number of cycles that bit 15 reads high, or the cycle in which `mgmt_ready` rises, so both counts are measured exactly. A priority mistake shows up within one cycle of the pin changing, as a stale bit 15 or a write that lands when it should have been dropped.

// File: rtl/phy_ctl_reset_mgr.sv
`timescale 1ns/1ps
module phy_ctl_reset_mgr #(
  parameter int NPORTS   = 2,
  parameter int CLK_HZ   = 200_000_000,
  parameter int READY_NS = 1_000_000,
  parameter int SRST_CYC = 16,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              strap_speed,
  input  logic              strap_aneg,
  input  logic              strap_duplex,
  input  logic [NPORTS-1:0] pwrdn_pin,
  input  logic              mgmt_wr,
  input  logic [PW-1:0]     mgmt_port,
  input  logic [15:0]       mgmt_wdata,
  output logic [15:0]       mgmt_rdata,
  output logic              mgmt_ready,
  output logic [NPORTS-1:0] port_oe,
  output logic [NPORTS-1:0] port_en
);
  localparam longint WAIT_L   = (longint'(CLK_HZ) * longint'(READY_NS)) / 64'd1_000_000_000;
  localparam int     WAIT_CYC = (WAIT_L < 1) ? 1 : int'(WAIT_L);
  localparam int     WW       = $clog2(WAIT_CYC + 1);
  localparam int     SW       = $clog2(SRST_CYC + 1);

  logic [WW-1:0] wait_q;
  logic [2:0]    keep_q;
  logic [15:0]   word_rd [NPORTS];

  wire [15:0] strap_word = {2'b00, strap_speed, strap_aneg, 3'b000, strap_duplex, 8'h00};
  wire [15:0] keep_word  = {2'b00, keep_q[2], keep_q[1], 3'b000, keep_q[0], 8'h00};
  wire        port_ok    = int'(mgmt_port) < NPORTS;

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      wait_q <= WW'(WAIT_CYC);
      keep_q <= {strap_speed, strap_aneg, strap_duplex};
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign mgmt_ready = !hw_rst && (wait_q == '0);

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic [15:0]   ctl_q;
    logic [SW-1:0] sr_q;
    wire           busy  = (sr_q != '0);
    wire           wr_ok = mgmt_wr && port_ok && (mgmt_port == PW'(i)) && mgmt_ready
                           && !pwrdn_pin[i] && !busy;

    always_ff @(posedge clk) begin
      if (hw_rst) begin
        ctl_q <= strap_word;
        sr_q  <= '0;
      end else if (pwrdn_pin[i]) begin
        ctl_q <= keep_word;
        sr_q  <= '0;
      end else if (busy) begin
        sr_q <= sr_q - 1'b1;
      end else if (wr_ok) begin
        if (mgmt_wdata[15]) begin
          ctl_q <= keep_word;
          sr_q  <= SW'(SRST_CYC);
        end else begin
          ctl_q <= {1'b0, mgmt_wdata[14:0]};
        end
      end
    end

    assign word_rd[i] = {busy, ctl_q[14:0]};
    assign port_oe[i] = !hw_rst && !pwrdn_pin[i];
    assign port_en[i] = port_oe[i] && !ctl_q[11];

    // R1
    strap_load_chk: assert property (@(posedge clk) disable iff (hw_rst)
      $fell(hw_rst) |-> (ctl_q[13] == keep_q[2] && ctl_q[12] == keep_q[1] && ctl_q[8] == keep_q[0]));
    // R2
    srst_restore_chk: assert property (@(posedge clk) disable iff (hw_rst)
      (wr_ok && mgmt_wdata[15] && !pwrdn_pin[i]) |=> (ctl_q == keep_word && word_rd[i][15]));
    // R3
    zero_bit15_chk: assert property (@(posedge clk) disable iff (hw_rst)
      (wr_ok && !mgmt_wdata[15] && !pwrdn_pin[i]) |=> !word_rd[i][15]);
    // R4
    closed_hold_chk: assert property (@(posedge clk) disable iff (hw_rst)
      (!mgmt_ready && !pwrdn_pin[i]) |=> $stable(ctl_q));
    // R8
    pin_release_chk: assert property (@(posedge clk) disable iff (hw_rst)
      $fell(pwrdn_pin[i]) |-> (word_rd[i] == keep_word));
  end

  always_comb begin
    mgmt_rdata = 16'hFFFF;
    if (mgmt_ready && port_ok && !pwrdn_pin[mgmt_port]) mgmt_rdata = word_rd[mgmt_port];
  end

  // R4
  ready_sticky_chk: assert property (@(posedge clk) disable iff (hw_rst)
    mgmt_ready |=> mgmt_ready);
endmodule

// File: tb/phy_ctl_reset_mgr_test.sv
`timescale 1ns/1ps
module phy_ctl_reset_mgr_test;
  localparam int NP = 2, SRST = 16, WAITC = 40;
  logic clk = 0, hw_rst = 1, s_spd = 0, s_an = 0, s_dpx = 0, mgmt_wr = 0;
  logic [NP-1:0] pin = '0;
  logic [0:0] mport = '0;
  logic [15:0] wdata = '0, rdata;
  logic ready;
  logic [NP-1:0] oe, en;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [2:0] latched;
  logic [15:0] expw [NP];

  phy_ctl_reset_mgr #(.NPORTS(NP), .CLK_HZ(200_000_000), .READY_NS(200), .SRST_CYC(SRST)) uut (
    .clk(clk), .hw_rst(hw_rst), .strap_speed(s_spd), .strap_aneg(s_an), .strap_duplex(s_dpx),
    .pwrdn_pin(pin), .mgmt_wr(mgmt_wr), .mgmt_port(mport), .mgmt_wdata(wdata),
    .mgmt_rdata(rdata), .mgmt_ready(ready), .port_oe(oe), .port_en(en));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dflt(input logic [2:0] s);
    return {2'b00, s[2], s[1], 3'b000, s[0], 8'h00};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int p, output logic [15:0] v);
    mport = 1'(p); #1; v = rdata;
  endtask

  task automatic wr(input int p, input logic [15:0] d);
    @(negedge clk); mport = 1'(p); wdata = d; mgmt_wr = 1;
    @(negedge clk); mgmt_wr = 0;
  endtask

  task automatic hw_reset(input logic [2:0] s);
    int n;
    @(negedge clk); hw_rst = 1; {s_spd, s_an, s_dpx} = s;
    repeat (3) @(negedge clk);
    #1;
    // R5
    chk("R5 oe in reset", 16'(oe), 16'h0);
    chk("R5 en in reset", 16'(en), 16'h0);
    @(negedge clk); hw_rst = 0; latched = s;
    n = 0;
    mport = 0; wdata = 16'h4321; mgmt_wr = 1;
    #1;
    // R4
    chk("R4 read blocked", rdata, 16'hFFFF);
    @(negedge clk); n++; mgmt_wr = 0;
    {s_spd, s_an, s_dpx} = ~s;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
    chk("R4 wait length", 16'(n), 16'(WAITC));
    for (int p = 0; p < NP; p++) expw[p] = dflt(s);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd2024));
    hw_reset(3'b101);
    // R1
    for (int p = 0; p < NP; p++) begin rd(p, v); chk("R1 strap word", v, dflt(3'b101)); end
    chk("R1 enables", 16'({oe, en}), 16'hF);

    for (int k = 0; k < 120; k++) begin
      int p = int'($urandom_range(0, NP-1));
      logic [15:0] d = 16'($urandom) & 16'h7FFF;
      wr(p, d); expw[p] = d;
      for (int q = 0; q < NP; q++) begin
        rd(q, v);
        // R9
        chk("R9 random write", v, expw[q]);
        // R6
        chk("R6 port_en", 16'(en[q]), 16'(!expw[q][11]));
        chk("R6 port_oe", 16'(oe[q]), 16'h1);
      end
    end

    {s_spd, s_an, s_dpx} = 3'b010;
    wr(0, 16'h8000 | (16'($urandom) & 16'h7FFF));
    n = 0;
    rd(0, v);
    while (v[15] && n < 100) begin n++; @(negedge clk); rd(0, v); end
    // R3
    chk("R3 bit15 duration", 16'(n), 16'(SRST));
    // R2
    chk("R2 restored word", v, dflt(latched));
    rd(1, v);
    chk("R9 other port", v, expw[1]);
    expw[0] = dflt(latched);

    wr(1, 16'hC000);
    wr(1, 16'h1234);
    rd(1, v);
    chk("R3 read during srst", v, dflt(latched) | 16'h8000);
    repeat (SRST) @(negedge clk);
    rd(1, v);
    chk("R3 write ignored", v, dflt(latched));
    expw[1] = dflt(latched);
    wr(1, 16'h0800);
    rd(1, v);
    chk("R3 zero bit15 write", v, 16'h0800);
    chk("R6 bit11", 16'({oe[1], en[1]}), 16'h2);
    expw[1] = 16'h0800;

    @(negedge clk); pin[1] = 1; #1;
    rd(1, v);
    // R7
    chk("R7 read blocked", v, 16'hFFFF);
    chk("R7 outputs", 16'({oe[1], en[1]}), 16'h0);
    wr(1, 16'h0123);
    rd(0, v);
    chk("R9 port0 during pin1", v, expw[0]);
    @(negedge clk); pin[1] = 0; #1;
    rd(1, v);
    // R8
    chk("R8 reload", v, dflt(latched));
    expw[1] = dflt(latched);

    wr(0, 16'h2100);
    wr(0, 16'h8000);
    repeat (3) @(negedge clk);
    pin[0] = 1;
    @(negedge clk); pin[0] = 0; #1;
    rd(0, v);
    // R10
    chk("R10 pin cancels srst", v, dflt(latched));
    wr(0, 16'h0042);
    rd(0, v);
    chk("R10 writes after cancel", v, 16'h0042);

    hw_reset(3'b011);
    for (int p = 0; p < NP; p++) begin rd(p, v); chk("R1 second reset", v, dflt(3'b011)); end
    wr(1, 16'h8000);
    repeat (SRST + 1) @(negedge clk);
    rd(1, v);
    chk("R2 after second reset", v, dflt(3'b011));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule